// File: doc/BRIEF.md
# Interrupt Distributor with End-of-Interrupt Re-arm

This block gathers up to fifty interrupt sources and drives one interrupt line per source towards a processor. A rising edge on a source input, or a software write of a 1 to that source's status bit, counts as one event. Each event sets a sticky status bit and adds one to a small pending counter that saturates at its maximum value. When a source is armed and its counter is non-zero, its output gives a single-cycle pulse and the source becomes disarmed.

Software runs the block over a single-cycle register bus. The status, status-clear and count registers are separate, and writing one never changes the others. The interrupt handler clears the status bit, subtracts the events it has handled from the counter, and then writes the source index to the end-of-interrupt register. That write re-arms the source. If events are still pending, the output pulses again straight away.

Top module: `irq_dist`

## Requirements
- R1: A read of address 0x000 returns the revision word: major revision in bits 15:8, minor revision in bits 7:0, zero above. The default is 0x0000_0102.
- R2: A rising edge on `src_i[n]` is one event. It sets status bit n and increments count n. A source held high produces no further events.
- R3: `irq_o[n]` is high for exactly one cycle when source n is armed and count n is non-zero. The source then stays disarmed and does not pulse again until its end-of-interrupt write.
- R4: A write to 0x010 with `wdata_i[7:0]` = n re-arms source n. If count n is non-zero, `irq_o[n]` pulses in the cycle after the write. This write changes no status bit and no count.
- R5: A write to status word w (address 0x200 + 4·w) injects one event for each source whose bit is 1 in the written data.
- R6: A write to status-clear word w (address 0x280 + 4·w) clears the status bits at the 1 positions. It changes neither the count nor the armed state. A read of this window returns the status words.
- R7: Count n saturates at 3, and further events leave it at 3.
- R8: A write of v to address 0x300 + 4·n subtracts v from count n and floors the result at zero. A write of v = 0 clears the count.
- R9: When an event and a count write hit the same source in the same cycle, the subtraction is applied first and the increment second. The result is still saturated at 3.
- R10: Sources 0–31 map to status word 0 bits 0–31. Sources 32–47 map to word 1 bits 0–15. Sources 48–49 map to word 4 bits 0–1. Words 2 and 3 and all unmapped bits read as zero, and writes to them have no effect.
- R11: After reset, all status bits and counts are zero, every source is armed, and no output is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Write enable, valid with req_i |
| addr_i | input | 12 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from addr_i |
| src_i | input | 50 | Interrupt source inputs |
| irq_o | output | 50 | One-cycle interrupt pulse per source |

## Verification
Two operations can reach the same pending counter on one clock edge: a software write to the counter and a rising edge on the matching source input. The bench drives both at the same falling clock edge, so that the next rising edge samples both together. The subtract-then-increment order is judged from the count read back: a full clear together with an edge must leave 1, and a subtract of one from the saturated value together with an edge must leave 3. Separately, end-of-interrupt writes are timed against the counter value, and the bench counts output pulses per source to confirm when a pulse is given and when it is withheld.

// File: rtl/irq_dist_pkg.sv
package irq_dist_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] A_REV  = 12'h000;
  localparam logic [ADDR_W-1:0] A_EOI  = 12'h010;
  localparam logic [ADDR_W-1:0] A_STAT = 12'h200;
  localparam logic [ADDR_W-1:0] A_SCLR = 12'h280;
  localparam logic [ADDR_W-1:0] A_CNT  = 12'h300;

  localparam int STAT_WORDS = 5;

  // source -> status word
  function automatic int word_of(int i);
    if (i < 32) return 0;
    else if (i < 48) return 1;
    else return 4;
  endfunction

  // source -> bit inside its status word
  function automatic int bit_of(int i);
    if (i < 32) return i;
    else if (i < 48) return i - 32;
    else return i - 48;
  endfunction
endpackage

// File: rtl/irq_dist_regdec.sv
module irq_dist_regdec
  import irq_dist_pkg::*;
#(
  parameter int NUM_SRC = 50
) (
  input  logic                req_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [NUM_SRC-1:0]  set_o,
  output logic [NUM_SRC-1:0]  clr_o,
  output logic [NUM_SRC-1:0]  cnt_wr_o,
  output logic [NUM_SRC-1:0]  eoi_o
);
  logic wr;
  assign wr = req_i & we_i;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_dec
    localparam int W = word_of(i);
    localparam int B = bit_of(i);
    assign set_o[i]    = wr && (addr_i == A_STAT + ADDR_W'(4 * W)) && wdata_i[B];
    assign clr_o[i]    = wr && (addr_i == A_SCLR + ADDR_W'(4 * W)) && wdata_i[B];
    assign cnt_wr_o[i] = wr && (addr_i == A_CNT + ADDR_W'(4 * i));
    assign eoi_o[i]    = wr && (addr_i == A_EOI) && (wdata_i[7:0] == 8'(i));
  end
endmodule

// File: rtl/irq_dist_src.sv
module irq_dist_src
  import irq_dist_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              src_i,
  input  logic              set_i,
  input  logic              clr_i,
  input  logic              cnt_wr_i,
  input  logic [DATA_W-1:0] sub_i,
  input  logic              eoi_i,
  output logic              status_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              irq_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             src_q, status_q, armed_q;
  logic [CNT_W-1:0] cnt_q, base, cnt_d;
  logic             edge_ev, ev;

  assign edge_ev = src_i & ~src_q;
  assign ev      = edge_ev | set_i;

  // subtract first, then count the new event
  always_comb begin
    base = cnt_q;
    if (cnt_wr_i) begin
      if (sub_i == '0 || sub_i >= DATA_W'(cnt_q)) base = '0;
      else                                        base = cnt_q - CNT_W'(sub_i);
    end
    cnt_d = (ev && base != CNT_MAX) ? base + CNT_W'(1) : base;
  end

  assign irq_o    = armed_q & (cnt_q != '0);
  assign status_o = status_q;
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q    <= 1'b0;
      status_q <= 1'b0;
      armed_q  <= 1'b1;
      cnt_q    <= '0;
    end else begin
      src_q <= src_i;
      cnt_q <= cnt_d;
      if (ev)         status_q <= 1'b1;
      else if (clr_i) status_q <= 1'b0;
      if (eoi_i)      armed_q  <= 1'b1;
      else if (irq_o) armed_q  <= 1'b0;
    end
  end

  p_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !eoi_i |=> !irq_o);
  p_eoi_fire_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoi_i && cnt_q != '0 && !cnt_wr_i |=> irq_o);
  p_inject_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> status_o);
  p_clr_keeps_cnt_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !ev && !cnt_wr_i |=> !status_o && $stable(cnt_q));
  p_sat_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q == CNT_MAX && !cnt_wr_i |=> cnt_q == CNT_MAX);
endmodule

// File: rtl/irq_dist.sv
module irq_dist
  import irq_dist_pkg::*;
#(
  parameter int          NUM_SRC   = 50,
  parameter int          CNT_W     = 2,
  parameter logic [7:0]  REV_MAJOR = 8'h01,
  parameter logic [7:0]  REV_MINOR = 8'h02
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [11:0]        addr_i,
  input  logic [31:0]        wdata_i,
  output logic [31:0]        rdata_o,
  input  logic [NUM_SRC-1:0] src_i,
  output logic [NUM_SRC-1:0] irq_o
);
  logic [NUM_SRC-1:0]            set_v, clr_v, cnt_wr_v, eoi_v, status_v;
  logic [NUM_SRC-1:0][CNT_W-1:0] cnt_v;
  logic [STAT_WORDS-1:0][DATA_W-1:0] stat_w;

  irq_dist_regdec #(.NUM_SRC(NUM_SRC)) u_dec (
    .req_i    (req_i),
    .we_i     (we_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .set_o    (set_v),
    .clr_o    (clr_v),
    .cnt_wr_o (cnt_wr_v),
    .eoi_o    (eoi_v)
  );

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    irq_dist_src #(.CNT_W(CNT_W)) u_src (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .src_i    (src_i[i]),
      .set_i    (set_v[i]),
      .clr_i    (clr_v[i]),
      .cnt_wr_i (cnt_wr_v[i]),
      .sub_i    (wdata_i),
      .eoi_i    (eoi_v[i]),
      .status_o (status_v[i]),
      .cnt_o    (cnt_v[i]),
      .irq_o    (irq_o[i])
    );
  end

  always_comb begin
    stat_w = '0;
    for (int i = 0; i < NUM_SRC; i++) stat_w[word_of(i)][bit_of(i)] = status_v[i];
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == A_REV) rdata_o = {16'h0, REV_MAJOR, REV_MINOR};
    for (int w = 0; w < STAT_WORDS; w++) begin
      if (addr_i == A_STAT + ADDR_W'(4 * w) || addr_i == A_SCLR + ADDR_W'(4 * w))
        rdata_o = stat_w[w];
    end
    for (int i = 0; i < NUM_SRC; i++) begin
      if (addr_i == A_CNT + ADDR_W'(4 * i)) rdata_o = DATA_W'(cnt_v[i]);
    end
  end

  initial begin
    a_num_src_r10: assert (NUM_SRC >= 1 && NUM_SRC <= 50);
  end
endmodule

// File: tb/irq_dist_tb_top.sv
module irq_dist_tb_top;
  localparam int N = 50;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req = 1'b0, we = 1'b0;
  logic [11:0]  addr = '0;
  logic [31:0]  wdata = '0;
  logic [31:0]  rdata;
  logic [N-1:0] src = '0;
  logic [N-1:0] irq;

  int checks = 0, errors = 0;
  int pulses [N];

  always #10 clk = ~clk;

  irq_dist dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .src_i(src), .irq_o(irq)
  );

  initial for (int i = 0; i < N; i++) pulses[i] = 0;
  always @(negedge clk) for (int i = 0; i < N; i++) if (irq[i]) pulses[i]++;

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=0x%08h exp=0x%08h", r, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk); req = 1; we = 0; addr = a;
    #1 d = rdata; req = 0;
  endtask

  task automatic pulse_src(int n);
    @(negedge clk); src[n] = 1;
    @(negedge clk); src[n] = 0;
  endtask

  task automatic idle(int c);
    repeat (c) @(negedge clk);
  endtask

  function automatic logic [11:0] cnt_a(int n);
    return 12'h300 + 12'(4 * n);
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    chk("R11 irq idle", 32'(irq != 0), 0);
    rd(12'h000, d); chk("R1 revision", d, 32'h0000_0102);
    rd(12'h200, d); chk("R11 status w0", d, 0);
    rd(12'h210, d); chk("R11 status w4", d, 0);
    rd(cnt_a(0), d); chk("R11 count0", d, 0);
  endtask

  task automatic t_edge();
    logic [31:0] d;
    pulse_src(5); idle(2);
    rd(12'h200, d); chk("R2 status bit5", d, 32'h20);
    rd(cnt_a(5), d); chk("R2 count5", d, 1);
    chk("R3 first pulse", pulses[5], 1);
    @(negedge clk); src[5] = 1; idle(5); src[5] = 0; idle(2);
    rd(cnt_a(5), d); chk("R2 level counts once", d, 2);
    chk("R3 no refire before eoi", pulses[5], 1);
  endtask

  task automatic t_eoi();
    logic [31:0] d;
    wr(12'h010, 5); idle(2);
    chk("R4 eoi refires", pulses[5], 2);
    rd(12'h200, d); chk("R4 status kept", d, 32'h20);
    rd(cnt_a(5), d); chk("R4 count kept", d, 2);
    wr(cnt_a(5), 2); wr(12'h010, 5); idle(2);
    chk("R4 no fire on zero count", pulses[5], 2);
    pulse_src(5); idle(2);
    chk("R4 armed source fires on event", pulses[5], 3);
  endtask

  task automatic t_sat();
    logic [31:0] d;
    for (int k = 0; k < 5; k++) pulse_src(40);
    idle(1);
    rd(cnt_a(40), d); chk("R7 saturate at 3", d, 3);
    rd(12'h204, d); chk("R10 source40 word1 bit8", d, 32'h100);
    chk("R3 single pulse", pulses[40], 1);
  endtask

  task automatic t_sub();
    logic [31:0] d;
    wr(cnt_a(40), 1); rd(cnt_a(40), d); chk("R8 subtract 1", d, 2);
    wr(cnt_a(40), 7); rd(cnt_a(40), d); chk("R8 floor at zero", d, 0);
    pulse_src(40); pulse_src(40); idle(1);
    rd(cnt_a(40), d); chk("R8 refill", d, 2);
    wr(cnt_a(40), 0); rd(cnt_a(40), d); chk("R8 zero clears", d, 0);
  endtask

  task automatic t_swset();
    logic [31:0] d;
    wr(12'h210, 32'h2); idle(2);
    rd(12'h210, d); chk("R5 inject status", d, 32'h2);
    rd(cnt_a(49), d); chk("R5 inject count", d, 1);
    rd(cnt_a(48), d); chk("R5 untouched neighbour", d, 0);
    chk("R5 inject pulse", pulses[49], 1);
    wr(12'h208, '1); wr(12'h20C, '1);
    rd(12'h208, d); chk("R10 word2 zero", d, 0);
    rd(12'h20C, d); chk("R10 word3 zero", d, 0);
    wr(12'h204, 32'hFFFF_0000);
    rd(12'h204, d); chk("R10 word1 upper unused", d, 32'h100);
  endtask

  task automatic t_clr();
    logic [31:0] d;
    wr(12'h290, 32'h2);
    rd(12'h210, d); chk("R6 status cleared", d, 0);
    rd(cnt_a(49), d); chk("R6 count kept", d, 1);
    rd(12'h280, d); chk("R6 clear window reads status", d, 32'h20);
    wr(12'h280, 32'h20);
    rd(12'h200, d); chk("R6 clear word0", d, 0);
    chk("R6 no pulse from clear", pulses[49], 1);
    wr(12'h010, 49); idle(2);
    chk("R6 armed state kept", pulses[49], 2);
  endtask

  task automatic t_same();
    logic [31:0] d;
    for (int k = 0; k < 3; k++) wr(12'h200, 32'h80);
    rd(cnt_a(7), d); chk("R9 preload", d, 3);
    @(negedge clk); req = 1; we = 1; addr = cnt_a(7); wdata = 3; src[7] = 1;
    @(negedge clk); req = 0; we = 0; src[7] = 0;
    rd(cnt_a(7), d); chk("R9 clear then increment", d, 1);
    wr(12'h200, 32'h80); wr(12'h200, 32'h80);
    @(negedge clk); req = 1; we = 1; addr = cnt_a(7); wdata = 1; src[7] = 1;
    @(negedge clk); req = 0; we = 0; src[7] = 0;
    rd(cnt_a(7), d); chk("R9 saturated after subtract", d, 3);
    chk("R3 one pulse for source7", pulses[7], 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle(1);
    t_reset();
    t_edge();
    t_eoi();
    t_sat();
    t_sub();
    t_swset();
    t_clr();
    t_same();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, errors);
    $finish;
  end
endmodule